// File: doc/BRIEF.md
# I2C Transaction Event Interrupt Unit

This block sits beside an I2C master's bus engine. It gathers the engine's one-cycle event pulses into a sticky status register, qualifies them with a mask register, and drives a single interrupt line toward the processor. Four events are tracked: transaction complete, ACK error, high-speed NACK error and restart-segment done. The restart-segment and high-speed NACK events have status bits of their own.

Software uses a small word-addressed register bus. It reads the status word, writes the same value back to clear what it saw, and programs the mask. The block also holds the launch register. Writing it sends a one-cycle go pulse to the engine, a one-cycle trigger for the next segment of a multi-restart transfer, or sets a held level that selects multi-restart operation.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: After synchronous reset the status, mask and restart-configuration bits are 0, and `irq_o`, `go_o` and `seg_trig_o` are low.
- R2: Each event pulse sets its status bit: complete at bit 0, ACK error at bit 1, high-speed NACK at bit 2, restart-segment done at bit 4. The bit is visible after the same clock edge, and it stays set while no clear is written.
- R3: A write to word address 0 (status) clears every status bit written as 1 and leaves bits written as 0 unchanged. Writing back the value just read clears the register.
- R4: When an event pulse and a clear of the same bit occur in one cycle, the bit ends set. A later read returns it as 1.
- R5: An ACK-error pulse followed one cycle later by a complete pulse leaves both bits 1 and 0 set.
- R6: The mask register is at word address 1 and uses the status bit positions. `irq_o` is high exactly when some status bit and its mask bit are both 1. It changes on the same edge as the status and mask registers.
- R7: Writing bit 0 of word address 2 (start) raises `go_o` for exactly one cycle after the write edge. The bit reads back as 0.
- R8: Writing bit 14 of the start register raises `seg_trig_o` for exactly one cycle and reads back as 0. Bit 15 is a held restart-configuration level on `rs_cfg_o`. It is rewritten by every start write and reads back as stored.
- R9: Reserved bits read as 0 and ignore writes: status and mask bits other than 0, 1, 2 and 4, start bits other than 15, and every bit of word address 3.
- R10: `bus_rdata_o` is registered. After each edge it holds the addressed register's value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_done_i | input | 1 | Transaction-complete pulse |
| evt_ackerr_i | input | 1 | ACK-error pulse |
| evt_hsnack_i | input | 1 | High-speed NACK-error pulse |
| evt_rsdone_i | input | 1 | Restart-segment-done pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request |
| go_o | output | 1 | One-cycle transaction launch |
| seg_trig_o | output | 1 | One-cycle next-segment trigger |
| rs_cfg_o | output | 1 | Multi-restart configuration level |

## Verification
The bench sweeps all sixteen event combinations against all sixteen mask settings. This catches a misplaced bit, a wrong gate in the interrupt OR, or an interrupt that lags status by a cycle. It forces an event and a full clear into the same cycle on each bit in turn. A design that let the clear win would lose an interrupt and read the bit back as 0. It replays the ACK-error-then-complete sequence, which a non-sticky or overwriting status would lose. It also checks that launch pulses last one cycle, read back as 0, and that reserved bits stay 0 after all-ones writes.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  // status / mask bit positions (software decodes these)
  localparam int BIT_DONE    = 0;
  localparam int BIT_ACKERR  = 1;
  localparam int BIT_HSNACK  = 2;
  localparam int BIT_RSDONE  = 4;
  // start register bit positions
  localparam int BIT_GO      = 0;
  localparam int BIT_SEGTRIG = 14;
  localparam int BIT_RSCFG   = 15;
  // word addresses
  localparam int ADDR_STAT   = 0;
  localparam int ADDR_MASK   = 1;
  localparam int ADDR_START  = 2;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] VALID = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] stat_d_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      logic q;
      // a fresh event beats a clear in the same cycle
      assign stat_d_o[i] = evt_i[i] | (q & ~clr_i[i]);
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= stat_d_o[i];
      end
      assign stat_o[i] = q;

      assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
        evt_i[i] |=> stat_o[i]);
      assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (stat_o[i] && !clr_i[i]) |=> stat_o[i]);
      assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_i[i] && !evt_i[i]) |=> !stat_o[i]);
      assert_evt_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_i[i] && evt_i[i]) |=> stat_o[i]);
    end else begin : g_rsvd
      assign stat_d_o[i] = 1'b0;
      assign stat_o[i]   = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] VALID = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] mask_d_o
);
  assign mask_d_o = we_i ? (wdata_i & VALID) : mask_o;

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '0;
    else     mask_o <= mask_d_o;
  end

  assert_mask_rsvd_R9: assert property (@(posedge clk) disable iff (rst)
    (mask_o & ~VALID) == '0);
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/xfer_start_reg.sv
module xfer_start_reg (
  input  logic clk,
  input  logic rst,
  input  logic we_i,
  input  logic go_bit_i,
  input  logic trig_bit_i,
  input  logic cfg_bit_i,
  output logic go_o,
  output logic seg_trig_o,
  output logic rs_cfg_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      go_o       <= 1'b0;
      seg_trig_o <= 1'b0;
      rs_cfg_o   <= 1'b0;
    end else begin
      go_o       <= we_i & go_bit_i;
      seg_trig_o <= we_i & trig_bit_i;
      if (we_i) rs_cfg_o <= cfg_bit_i;
    end
  end

  assert_go_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (go_o && !(we_i && go_bit_i)) |=> !go_o);
  assert_trig_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (seg_trig_o && !(we_i && trig_bit_i)) |=> !seg_trig_o);
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(rs_cfg_o));
endmodule

// File: rtl/i2c_evt_irq_unit.sv
module i2c_evt_irq_unit
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_done_i,
  input  logic              evt_ackerr_i,
  input  logic              evt_hsnack_i,
  input  logic              evt_rsdone_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              go_o,
  output logic              seg_trig_o,
  output logic              rs_cfg_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] VALID =
    (ONE << BIT_DONE) | (ONE << BIT_ACKERR) | (ONE << BIT_HSNACK) | (ONE << BIT_RSDONE);

  logic hit_stat, hit_mask, hit_start;
  assign hit_stat  = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_STAT));
  assign hit_mask  = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_MASK));
  assign hit_start = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_START));

  logic [DATA_W-1:0] evt_vec, clr_vec;
  always_comb begin
    evt_vec             = '0;
    evt_vec[BIT_DONE]   = evt_done_i;
    evt_vec[BIT_ACKERR] = evt_ackerr_i;
    evt_vec[BIT_HSNACK] = evt_hsnack_i;
    evt_vec[BIT_RSDONE] = evt_rsdone_i;
  end
  assign clr_vec = hit_stat ? bus_wdata_i : '0;

  logic [DATA_W-1:0] stat_q, stat_d, mask_q, mask_d;

  irq_stat_bank #(.DATA_W(DATA_W), .VALID(VALID)) u_stat (
    .clk(clk), .rst(rst), .evt_i(evt_vec), .clr_i(clr_vec),
    .stat_o(stat_q), .stat_d_o(stat_d));

  irq_mask_reg #(.DATA_W(DATA_W), .VALID(VALID)) u_mask (
    .clk(clk), .rst(rst), .we_i(hit_mask), .wdata_i(bus_wdata_i),
    .mask_o(mask_q), .mask_d_o(mask_d));

  xfer_start_reg u_start (
    .clk(clk), .rst(rst), .we_i(hit_start),
    .go_bit_i(bus_wdata_i[BIT_GO]), .trig_bit_i(bus_wdata_i[BIT_SEGTRIG]),
    .cfg_bit_i(bus_wdata_i[BIT_RSCFG]),
    .go_o(go_o), .seg_trig_o(seg_trig_o), .rs_cfg_o(rs_cfg_o));

  // interrupt registered from next-state values: same edge as status/mask
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(stat_d & mask_d);
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == ADDR_W'(ADDR_STAT))  rd_mux = stat_q;
    if (bus_addr_i == ADDR_W'(ADDR_MASK))  rd_mux = mask_q;
    if (bus_addr_i == ADDR_W'(ADDR_START)) rd_mux[BIT_RSCFG] = rs_cfg_o;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata_o <= '0;
    else     bus_rdata_o <= rd_mux;
  end

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(stat_q & mask_q));
  assert_stat_rsvd_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~VALID) == '0);
  assert_go_needs_write_R7: assert property (@(posedge clk) disable iff (rst)
    go_o |-> $past(hit_start));
endmodule

// File: tb/tb_i2c_evt_irq_unit.sv
module tb_i2c_evt_irq_unit;
  localparam int DW = 16;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic e_done = 0, e_ack = 0, e_hs = 0, e_rs = 0;
  logic wr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq, go, trig, cfg;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_evt_irq_unit #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst),
    .evt_done_i(e_done), .evt_ackerr_i(e_ack), .evt_hsnack_i(e_hs), .evt_rsdone_i(e_rs),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .go_o(go), .seg_trig_o(trig), .rs_cfg_o(cfg));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 4-bit event code -> status word (bits 0,1,2,4)
  function automatic logic [DW-1:0] evmap(input logic [3:0] c);
    return DW'({c[3], 1'b0, c[2], c[1], c[0]});
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); wr = 0; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input logic [3:0] c);
    @(negedge clk); {e_rs, e_hs, e_ack, e_done} = c;
    @(negedge clk); {e_rs, e_hs, e_ack, e_done} = '0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq", DW'(irq), '0);
    check("R1 go/trig/cfg", DW'({go, trig, cfg}), '0);
    bus_read(0, r); check("R1 status", r, '0);
    bus_read(1, r); check("R1 mask", r, '0);
    bus_read(2, r); check("R1 start", r, '0);

    // R2/R3/R6 sweep: every event combination against every mask
    for (int m = 0; m < 16; m++) begin
      bus_write(1, evmap(4'(m)));
      for (int c = 0; c < 16; c++) begin
        pulse(4'(c));
        check("R6 irq", DW'(irq), DW'(|(evmap(4'(c)) & evmap(4'(m)))));
        repeat (2) @(negedge clk);
        bus_read(0, r);
        check("R2 status sticky", r, evmap(4'(c)));
        bus_write(0, r);   // R3 write back what was read
        check("R6 irq after clear", DW'(irq), '0);
        bus_read(0, r);
        check("R3 cleared", r, '0);
      end
    end

    // R3 partial clear: zeros leave bits alone
    pulse(4'hF);
    bus_write(0, DW'(16'h0005));
    bus_read(0, r); check("R3 partial", r, DW'(16'h0012));
    bus_write(0, DW'(16'hFFFF));

    // R4 event wins over same-cycle clear, each bit
    for (int b = 0; b < 4; b++) begin
      pulse(4'hF);
      @(negedge clk); wr = 1; addr = 0; wdata = '1;
      {e_rs, e_hs, e_ack, e_done} = 4'(1 << b);
      @(negedge clk); wr = 0; wdata = '0; {e_rs, e_hs, e_ack, e_done} = '0;
      bus_read(0, r); check("R4 event wins", r, evmap(4'(1 << b)));
      bus_write(0, r);
    end

    // R5 ack error then complete
    bus_write(1, '0);
    @(negedge clk); e_ack = 1;
    @(negedge clk); e_ack = 0; e_done = 1;
    @(negedge clk); e_done = 0;
    bus_read(0, r); check("R5 both latched", r, DW'(16'h0003));
    bus_write(0, r);

    // R7 go pulse
    bus_write(2, DW'(16'h0001));
    check("R7 go high", DW'(go), DW'(1));
    @(negedge clk); check("R7 go one cycle", DW'(go), '0);
    bus_read(2, r); check("R7 go reads 0", r, '0);

    // R8 segment trigger and config level
    bus_write(2, DW'(16'hC000));
    check("R8 trig high", DW'({trig, cfg}), DW'(2'b11));
    @(negedge clk); check("R8 trig one cycle", DW'({trig, cfg}), DW'(2'b01));
    bus_read(2, r); check("R8 start readback", r, DW'(16'h8000));
    bus_write(2, '0);
    check("R8 cfg cleared", DW'(cfg), '0);

    // R9 reserved bits
    bus_write(1, '1);
    bus_read(1, r); check("R9 mask rsvd", r, DW'(16'h0017));
    bus_write(2, DW'(16'h3FFE));
    bus_read(2, r); check("R9 start rsvd", r, '0);
    check("R9 no pulse", DW'({go, trig, cfg}), '0);
    bus_write(3, '1);
    bus_read(3, r); check("R9 addr3", r, '0);
    bus_read(0, r); check("R9 addr3 no effect", r, '0);
    bus_write(1, '0);

    // R10 read shows pre-write value on same-edge write
    @(negedge clk); wr = 1; addr = 1; wdata = DW'(16'h0010);
    @(negedge clk); wr = 0;
    check("R10 old value", rdata, '0);
    @(negedge clk); check("R10 new value", rdata, DW'(16'h0010));

    // R1 reset again clears everything
    pulse(4'hF);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 irq after reset", DW'(irq), '0);
    bus_read(0, r); check("R1 status after reset", r, '0);
    bus_read(1, r); check("R1 mask after reset", r, '0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule